// File: doc/BRIEF.md
# Row-Column Banked Instruction Counter

This block keeps the address of the next instruction for a character-addressed machine whose storage is split into banks. Each bank is a 32 by 32 grid of six-bit cells. The counter, however, only ever walks rows 1 to 31 and columns 1 to 31 of each bank. The address it presents is a bank index, a row coordinate and a column coordinate.

After each instruction fetch, the fetch logic pulses the advance input. It also supplies the instruction length in characters, which is 7 for the long format and 5 for the short one. That length is added to the column coordinate. A column sum above 31 wraps back into the range 1 to 31 and carries one into the row. A row above 31 wraps to 1 and carries into the bank.

The bank wraps after the last installed bank. The configuration input selects two or four installed banks. A jump uses the load port, which replaces all three coordinates in one cycle. A load that names a coordinate the counter can never produce is refused: the address is kept, and an error flag pulses.

Top module: `rc_fetch_counter`

## Requirements
- R1: During reset and in the first cycle after it, the outputs read bank code 0 (the first bank), row 1, column 1, and the error flag is 0.
- R2: When advance is high and load is low, and column plus length is at most 31, the column becomes column plus length on the next clock edge. Row and bank are unchanged. The length input is an unsigned count of characters; 5 and 7 are the values used.
- R3: When advance is high and load is low, column plus length is above 31, and row is below 31, the column becomes column plus length minus 31 and the row increases by one. For example, column 29 plus 7 gives column 5 of the next row.
- R4: In four-bank mode (configuration input 1), a column carry out of row 31 sets the row to 1 and moves the bank code 0 to 1, 1 to 2, 2 to 3 and 3 to 0. Bank codes 0 to 3 stand for the first to fourth bank.
- R5: In two-bank mode (configuration input 0), a column carry out of row 31 moves the bank code 0 to 1 and 1 back to 0.
- R6: The row and column outputs stay within 1 to 31 at all times. The values 0 and 32 never appear.
- R7: A load with row and column in 1 to 31 and a bank code below the installed bank count replaces all three coordinates on the next edge. The load wins over an advance in the same cycle.
- R8: A load whose 6-bit row or column lies outside 1 to 31, or whose bank code is not below the installed bank count, leaves all coordinates unchanged, even when advance is also high. The error flag is then 1 in the following cycle only.
- R9: With load and advance both low, the coordinates hold. The error flag is 0 in any cycle that does not follow a refused load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| four_bank_i | input | 1 | 1: four banks installed, 0: two banks |
| adv_i | input | 1 | Advance by one instruction |
| adv_len_i | input | 3 | Instruction length in characters |
| load_i | input | 1 | Jump load strobe |
| load_bank_i | input | 2 | Bank code to load |
| load_row_i | input | 6 | Row to load (legal 1 to 31) |
| load_col_i | input | 6 | Column to load (legal 1 to 31) |
| bank_o | output | 2 | Current bank code |
| row_o | output | 5 | Current row |
| col_o | output | 5 | Current column |
| load_err_o | output | 1 | Pulse after a refused load |

## Verification
The bench checks the counter against a model that treats the address as one linear position: bank times 961 plus 31 times (row minus 1) plus (column minus 1), taken modulo the installed cell count. This gives an expected value that shares no logic with the per-coordinate wrap. A long pseudo-random mix of idle cycles and 5- and 7-character advances runs in both bank modes. That mix separates plain column steps, row carries, four-bank bank carries and two-bank wraps, and every step is labelled by which of these it was. A load sweep over all rows and columns 0 to 32, each paired with a competing advance, separates accepted jumps from refused ones. Loads of bank codes that are not installed, and hand-picked wrap points such as column 29 plus 7 on row 31, cover the edges.

// File: rtl/rcfc_pkg.sv
package rcfc_pkg;

    // Bank configuration selector
    typedef enum logic {
        CFG_TWO  = 1'b0,
        CFG_FOUR = 1'b1
    } bank_cfg_e;

    localparam int RC_COORD_MAX = 31;
    localparam int RC_LEN_W     = 3;
    localparam int RC_NB_FULL   = 4;
    localparam int RC_NB_HALF   = 2;

endpackage

// File: rtl/rcfc_wrap_step.sv
// One coordinate of the counter: adds an amount and wraps the result back
// into 1..MAX, reporting a carry into the next coordinate.
module rcfc_wrap_step #(
    parameter int W   = 5,
    parameter int MAX = 31,
    parameter int AW  = 3
) (
    input  logic [W-1:0]  cur_i,
    input  logic [AW-1:0] add_i,
    output logic [W-1:0]  nxt_o,
    output logic          carry_o
);
    localparam int SW = W + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum     = SW'(cur_i) + SW'(add_i);
        carry_o = (sum > SW'(MAX));
        if (carry_o) begin
            nxt_o = W'(sum - SW'(MAX));
        end else begin
            nxt_o = W'(sum);
        end
    end
endmodule

// File: rtl/rcfc_bank_step.sv
// Bank coordinate: advances on a row carry and wraps after the last installed bank.
module rcfc_bank_step #(
    parameter int BW      = 2,
    parameter int NB_FULL = 4,
    parameter int NB_HALF = 2
) (
    input  logic [BW-1:0] bank_i,
    input  logic          inc_i,
    input  logic          four_i,
    output logic [BW-1:0] nxt_o
);
    logic [BW-1:0] last;

    always_comb begin
        last = four_i ? BW'(NB_FULL - 1) : BW'(NB_HALF - 1);
        if (!inc_i) begin
            nxt_o = bank_i;
        end else if (bank_i == last) begin
            nxt_o = '0;
        end else begin
            nxt_o = bank_i + BW'(1);
        end
    end
endmodule

// File: rtl/rcfc_load_check.sv
// Decides whether a jump target can be produced by the counter.
module rcfc_load_check #(
    parameter int CW      = 5,
    parameter int MAX     = 31,
    parameter int BW      = 2,
    parameter int NB_FULL = 4,
    parameter int NB_HALF = 2
) (
    input  logic [CW:0]   row_i,
    input  logic [CW:0]   col_i,
    input  logic [BW-1:0] bank_i,
    input  logic          four_i,
    output logic          ok_o
);
    localparam int NCOORD = 2;

    logic [NCOORD-1:0][CW:0] coord;
    logic [NCOORD-1:0]       in_range;
    logic                    bank_ok;

    assign coord = {row_i, col_i};

    genvar g;
    generate
        for (g = 0; g < NCOORD; g++) begin : g_coord
            assign in_range[g] = (coord[g] != '0) && (coord[g] <= (CW+1)'(MAX));
        end
    endgenerate

    always_comb begin
        if (four_i) begin
            bank_ok = int'(bank_i) < NB_FULL;
        end else begin
            bank_ok = int'(bank_i) < NB_HALF;
        end
        ok_o = (&in_range) && bank_ok;
    end
endmodule

// File: rtl/rc_fetch_counter.sv
module rc_fetch_counter
    import rcfc_pkg::*;
#(
    parameter int COORD_MAX = RC_COORD_MAX,
    parameter int LEN_W     = RC_LEN_W,
    parameter int NB_FULL   = RC_NB_FULL,
    parameter int NB_HALF   = RC_NB_HALF
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                four_bank_i,
    input  logic                                adv_i,
    input  logic [LEN_W-1:0]                    adv_len_i,
    input  logic                                load_i,
    input  logic [$clog2(NB_FULL)-1:0]          load_bank_i,
    input  logic [$clog2(COORD_MAX+1):0]        load_row_i,
    input  logic [$clog2(COORD_MAX+1):0]        load_col_i,
    output logic [$clog2(NB_FULL)-1:0]          bank_o,
    output logic [$clog2(COORD_MAX+1)-1:0]      row_o,
    output logic [$clog2(COORD_MAX+1)-1:0]      col_o,
    output logic                                load_err_o
);
    localparam int CW = $clog2(COORD_MAX + 1);
    localparam int BW = $clog2(NB_FULL);

    typedef struct packed {
        logic [BW-1:0] bank;
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } rc_addr_t;

    rc_addr_t      state_d, state_q;
    logic          err_d, err_q;

    logic [CW-1:0] col_nxt, row_nxt;
    logic [BW-1:0] bank_nxt;
    logic          col_carry, row_carry;
    logic          ld_ok;

    rcfc_wrap_step #(.W(CW), .MAX(COORD_MAX), .AW(LEN_W)) i_col_step (
        .cur_i   (state_q.col),
        .add_i   (adv_len_i),
        .nxt_o   (col_nxt),
        .carry_o (col_carry)
    );

    rcfc_wrap_step #(.W(CW), .MAX(COORD_MAX), .AW(1)) i_row_step (
        .cur_i   (state_q.row),
        .add_i   (col_carry),
        .nxt_o   (row_nxt),
        .carry_o (row_carry)
    );

    rcfc_bank_step #(.BW(BW), .NB_FULL(NB_FULL), .NB_HALF(NB_HALF)) i_bank_step (
        .bank_i (state_q.bank),
        .inc_i  (row_carry),
        .four_i (four_bank_i),
        .nxt_o  (bank_nxt)
    );

    rcfc_load_check #(.CW(CW), .MAX(COORD_MAX), .BW(BW),
                      .NB_FULL(NB_FULL), .NB_HALF(NB_HALF)) i_load_check (
        .row_i  (load_row_i),
        .col_i  (load_col_i),
        .bank_i (load_bank_i),
        .four_i (four_bank_i),
        .ok_o   (ld_ok)
    );

    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        if (load_i) begin
            if (ld_ok) begin
                state_d.bank = load_bank_i;
                state_d.row  = load_row_i[CW-1:0];
                state_d.col  = load_col_i[CW-1:0];
            end else begin
                err_d = 1'b1;
            end
        end else if (adv_i) begin
            state_d.col  = col_nxt;
            state_d.row  = row_nxt;
            state_d.bank = bank_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{bank: '0, row: CW'(1), col: CW'(1)};
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    assign bank_o     = state_q.bank;
    assign row_o      = state_q.row;
    assign col_o      = state_q.col;
    assign load_err_o = err_q;

    // R6
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.row != '0) && (int'(state_q.row) <= COORD_MAX) &&
        (state_q.col != '0) && (int'(state_q.col) <= COORD_MAX));

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && (int'(state_q.col) + int'(adv_len_i) <= COORD_MAX))
        |=> (int'(state_q.col) == int'($past(state_q.col)) + int'($past(adv_len_i)))
            && $stable(state_q.row) && $stable(state_q.bank));

    // R5
    two_bank_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !four_bank_i && (state_q.bank == BW'(1)) &&
         (int'(state_q.row) == COORD_MAX) &&
         (int'(state_q.col) + int'(adv_len_i) > COORD_MAX))
        |=> (state_q.bank == '0) && (state_q.row == CW'(1)));

    // R7
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ld_ok)
        |=> (state_q.row == $past(load_row_i[CW-1:0])) &&
            (state_q.col == $past(load_col_i[CW-1:0])) &&
            (state_q.bank == $past(load_bank_i)) && !err_q);

    // R8
    bad_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ld_ok) |=> $stable(state_q) && err_q);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(state_q) && !err_q);
endmodule

// File: tb/test_rc_fetch_counter.sv
`timescale 1ns/1ps
module test_rc_fetch_counter;
    localparam int CELLS = 961;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       four_bank_i = 1'b1;
    logic       adv_i = 1'b0;
    logic [2:0] adv_len_i = 3'd7;
    logic       load_i = 1'b0;
    logic [1:0] load_bank_i = '0;
    logic [5:0] load_row_i = '0;
    logic [5:0] load_col_i = '0;
    logic [1:0] bank_o;
    logic [4:0] row_o, col_o;
    logic       load_err_o;

    int total = 0;
    int bad   = 0;
    int pos   = 0;
    int nb    = 4;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    rc_fetch_counter i_rc_fetch_counter (
        .clk(clk), .rst_n(rst_n), .four_bank_i(four_bank_i),
        .adv_i(adv_i), .adv_len_i(adv_len_i), .load_i(load_i),
        .load_bank_i(load_bank_i), .load_row_i(load_row_i), .load_col_i(load_col_i),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .load_err_o(load_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int err_exp);
        chk($sformatf("%s bank", tag), int'(bank_o), pos / CELLS);
        chk($sformatf("%s row", tag), int'(row_o), (pos % CELLS) / 31 + 1);
        chk($sformatf("%s col", tag), int'(col_o), pos % 31 + 1);
        chk($sformatf("%s err", tag), int'(load_err_o), err_exp);
        chk("R6 range", int'(row_o >= 1 && row_o <= 31 && col_o >= 1 && col_o <= 31), 1);
    endtask

    task automatic do_reset(input bit four);
        rst_n = 1'b0;
        four_bank_i = four;
        nb = four ? 4 : 2;
        adv_i = 1'b0;
        load_i = 1'b0;
        @(posedge clk); #1;
        pos = 0;
        chk_all("R1 in reset", 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk_all("R1 after reset", 0);
    endtask

    task automatic adv_cycle(input bit a, input int len);
        int pc, pr;
        string tag;
        pc = pos % 31 + 1;
        pr = (pos % CELLS) / 31 + 1;
        if (!a)                tag = "R9 idle";
        else if (pc + len <= 31) tag = "R2 col step";
        else if (pr < 31)      tag = "R3 row carry";
        else if (nb == 4)      tag = "R4 bank carry";
        else                   tag = "R5 two-bank wrap";
        adv_i = a;
        adv_len_i = 3'(len);
        load_i = 1'b0;
        @(posedge clk); #1;
        if (a) pos = (pos + len) % (nb * CELLS);
        chk_all(tag, 0);
        adv_i = 1'b0;
    endtask

    task automatic load_cycle(input int b, input int r, input int c, input bit a);
        bit ok;
        ok = (r >= 1 && r <= 31 && c >= 1 && c <= 31 && b < nb);
        load_i = 1'b1;
        load_bank_i = 2'(b);
        load_row_i = 6'(r);
        load_col_i = 6'(c);
        adv_i = a;
        adv_len_i = 3'd7;
        @(posedge clk); #1;
        if (ok) pos = b * CELLS + (r - 1) * 31 + (c - 1);
        chk_all(ok ? "R7 load" : "R8 refused load", ok ? 0 : 1);
        load_i = 1'b0;
        adv_i = 1'b0;
    endtask

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            adv_cycle(lf[1:0] != 2'b00, lf[2] ? 7 : 5);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Four-bank mode: random advances over several laps
        do_reset(1'b1);
        sweep(4000);
        // Explicit corners, four banks
        load_cycle(0, 5, 29, 1'b0);
        adv_cycle(1'b1, 7);                 // R3: 29+7 -> column 5, next row
        chk("R3 col 29+7", int'(col_o), 5);
        load_cycle(3, 31, 30, 1'b0);
        adv_cycle(1'b1, 5);                 // R4: bank 3 wraps to 0
        chk("R4 bank 3 to 0", int'(bank_o), 0);
        // Load sweep with competing advance
        for (int r = 0; r <= 32; r++) begin
            for (int c = 0; c <= 32; c++) begin
                load_cycle((r + c) % 4, r, c, 1'b1);
                if ((r + c) % 5 == 0) adv_cycle(1'b0, 7);
            end
        end
        load_cycle(0, 63, 1, 1'b1);
        // Two-bank mode
        do_reset(1'b0);
        sweep(3000);
        load_cycle(2, 4, 4, 1'b1);          // R8: bank not installed
        load_cycle(3, 4, 4, 1'b0);
        load_cycle(1, 31, 29, 1'b0);
        adv_cycle(1'b1, 7);                 // R5: bank 1 wraps to 0
        chk("R5 wrap col", int'(col_o), 5);
        chk("R5 wrap bank", int'(bank_o), 0);
        adv_cycle(1'b0, 5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule